// File: doc/BRIEF.md
# Bus-Slave Transmit Packet Writer

This block is the path by which a host processor hands an outgoing packet straight to the transmit side of a serial link, instead of letting a descriptor fetch engine read it from memory. The host writes a length word first, then as many 32-bit payload words as the length needs, one at a time or as an unbroken burst. The block cuts each word into bytes, least significant byte first, and stores them as 9-bit entries in an internal transmit FIFO. Once the counted bytes are in, it appends an end marker. The link encoder pops the FIFO from the other side.

Accesses that make no sense get an error response and raise a sticky interrupt flag. These are any read, and any write made while the transmit path is owned by the fetch engine. The host can abort a packet at any point, which closes it with an error end marker. Dropping the link-enable input empties the FIFO.

Top module: `pkt_push_port`

## Requirements
- R1: In the length state, an accepted write takes its low SIZE_W bits as the packet byte count and moves to the payload state. A count of zero is ignored: nothing is written to the FIFO and the block stays in the length state.
- R2: Each accepted payload word adds min(remaining, 4) entries with bit 8 = 0 and bits 7:0 taken from the word, least significant byte first. Unused upper bytes of the final word are discarded.
- R3: After the last counted byte, the entry 9'h100 (normal end of packet) follows, and the next write is again taken as a length.
- R4: A payload write is held off (s_done low) until the FIFO has room for all entries that word produces, including the end marker if there is one. Back-to-back writes with no idle cycle are all accepted in order, with no loss. The FIFO never overflows.
- R5: A write while fetch_mode = 1 completes in the same cycle with s_err = 1, sets irq_wrong_mode, writes nothing and leaves the packet state unchanged. A write while fetch_mode = 0 never gets s_err.
- R6: Any read (s_valid = 1, s_write = 0) completes in the same cycle with s_err = 1 and sets irq_rd_err.
- R7: A one-cycle pulse on abort_req, in either state, places the entry 9'h101 (error end of packet) after any bytes already accepted and returns the block to the length state.
- R8: While link_en = 0, the FIFO is emptied; tx_empty is 1 from the next clock edge on.
- R9: The interrupt flags are sticky. Writing a 1 to irq_clr[0] clears irq_wrong_mode and a 1 to irq_clr[1] clears irq_rd_err; a new event in the same cycle wins over the clear.
- R10: After reset the FIFO is empty, both interrupt flags are 0 and the block is in the length state.
- R11: tx_dout always shows the oldest FIFO entry, and tx_rd = 1 removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_mode | input | 1 | 1 = fetch engine owns transmit; slave writes are rejected |
| link_en | input | 1 | Link enabled; 0 flushes the FIFO |
| abort_req | input | 1 | One-cycle pulse that aborts the current packet |
| s_valid | input | 1 | Bus transfer request, held until s_done |
| s_write | input | 1 | 1 = write, 0 = read |
| s_wdata | input | 32 | Write data (length or payload word) |
| s_done | output | 1 | Transfer completes in this cycle |
| s_err | output | 1 | Error response, qualifies s_done |
| tx_rd | input | 1 | Pop the oldest FIFO entry |
| tx_dout | output | 9 | Oldest FIFO entry; bit 8 marks an end marker |
| tx_empty | output | 1 | FIFO holds no entry |
| irq_clr | input | 2 | Write-one-to-clear for the interrupt flags |
| irq_wrong_mode | output | 1 | Sticky flag: write in fetch mode |
| irq_rd_err | output | 1 | Sticky flag: read access |

## Verification
The assertions assume a host that keeps s_valid, s_write and s_wdata steady until it sees s_done, and that changes fetch_mode only between transfers. They also take abort_req to be a single-cycle pulse, since a level would close several packets. The bench drives all inputs on the falling edge and holds each request until s_done. It pulses abort for exactly one cycle and toggles the mode only with no request pending, so the stimulus stays inside these assumptions.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
  typedef enum logic {
    ST_LEN  = 1'b0,
    ST_DATA = 1'b1
  } wr_state_t;

  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_OK   = 2'd1,
    END_ERR  = 2'd2
  } end_kind_t;

  localparam logic [8:0] MARK_OK  = 9'h100;
  localparam logic [8:0] MARK_ERR = 9'h101;
endpackage

// File: rtl/ppp_fifo.sv
module ppp_fifo #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [AW:0]   free
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign do_wr   = wr_en && !flush && (count != (AW+1)'(DEPTH));
  assign do_rd   = rd_en && !flush && (count != '0);
  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign free    = (AW+1)'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ppp_serializer.sv
module ppp_serializer
  import ppp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ld,
  input  logic [31:0] ld_word,
  input  logic [2:0]  ld_nbytes,
  input  end_kind_t   ld_end,
  output logic        busy,
  output logic        out_valid,
  output logic [8:0]  out_data
);
  logic [31:0] word_q;
  logic [2:0]  left_q;
  end_kind_t   end_q;

  assign busy      = (left_q != 3'd0) || (end_q != END_NONE);
  assign out_valid = busy;

  always_comb begin
    if (left_q != 3'd0)      out_data = {1'b0, word_q[7:0]};
    else if (end_q == END_ERR) out_data = MARK_ERR;
    else                     out_data = MARK_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      left_q <= '0;
      end_q  <= END_NONE;
    end else if (ld) begin
      word_q <= ld_word;
      left_q <= ld_nbytes;
      end_q  <= ld_end;
    end else if (left_q != 3'd0) begin
      word_q <= {8'h00, word_q[31:8]};
      left_q <= left_q - 3'd1;
    end else if (end_q != END_NONE) begin
      end_q <= END_NONE;
    end
  end
endmodule

// File: rtl/ppp_ctrl.sv
module ppp_ctrl
  import ppp_pkg::*;
#(
  parameter int SIZE_W  = 16,
  parameter int FIFO_AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic             s_write,
  input  logic [31:0]      s_wdata,
  input  logic             fetch_mode,
  input  logic             abort_req,
  input  logic             ser_busy,
  input  logic [FIFO_AW:0] fifo_free,
  output logic             s_done,
  output logic             s_err,
  output logic             ld,
  output logic [31:0]      ld_word,
  output logic [2:0]       ld_nbytes,
  output end_kind_t        ld_end,
  output logic             set_wrong,
  output logic             set_rderr
);
  wr_state_t         state_q;
  logic [SIZE_W-1:0] remain_q;
  logic              abort_q;

  logic        is_rd, is_wm, push_wr, last, wr_ok, accept, abort_go;
  logic [2:0]  nbytes;
  logic [3:0]  need;
  logic [SIZE_W-1:0] new_len;

  assign is_rd   = s_valid && !s_write;
  assign is_wm   = s_valid && s_write && fetch_mode;
  assign push_wr = s_valid && s_write && !fetch_mode;
  assign new_len = s_wdata[SIZE_W-1:0];

  assign last   = (remain_q <= SIZE_W'(4));
  assign nbytes = last ? remain_q[2:0] : 3'd4;
  assign need   = {1'b0, nbytes} + {3'b000, last};

  assign abort_go = abort_q && !ser_busy && (fifo_free != '0);

  always_comb begin
    if (abort_q)               wr_ok = 1'b0;
    else if (state_q == ST_LEN) wr_ok = 1'b1;
    else wr_ok = !ser_busy && (32'(fifo_free) >= 32'(need));
  end

  assign accept    = push_wr && wr_ok;
  assign s_err     = is_rd || is_wm;
  assign s_done    = s_err || accept;
  assign set_wrong = is_wm;
  assign set_rderr = is_rd;

  assign ld        = abort_go || (accept && state_q == ST_DATA);
  assign ld_word   = s_wdata;
  assign ld_nbytes = abort_go ? 3'd0 : nbytes;

  always_comb begin
    if (abort_go)  ld_end = END_ERR;
    else if (last) ld_end = END_OK;
    else           ld_end = END_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_LEN;
      remain_q <= '0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= (abort_q && !abort_go) || abort_req;
      if (abort_go) begin
        state_q  <= ST_LEN;
        remain_q <= '0;
      end else if (accept) begin
        if (state_q == ST_LEN) begin
          if (new_len != '0) begin
            state_q  <= ST_DATA;
            remain_q <= new_len;
          end
        end else begin
          remain_q <= remain_q - SIZE_W'(nbytes);
          if (last) state_q <= ST_LEN;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_push_port.sv
module pkt_push_port
  import ppp_pkg::*;
#(
  parameter int SIZE_W  = 16,
  parameter int FIFO_AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fetch_mode,
  input  logic        link_en,
  input  logic        abort_req,
  input  logic        s_valid,
  input  logic        s_write,
  input  logic [31:0] s_wdata,
  output logic        s_done,
  output logic        s_err,
  input  logic        tx_rd,
  output logic [8:0]  tx_dout,
  output logic        tx_empty,
  input  logic [1:0]  irq_clr,
  output logic        irq_wrong_mode,
  output logic        irq_rd_err
);
  logic             ld, ser_busy, ser_valid, set_wrong, set_rderr;
  logic [31:0]      ld_word;
  logic [2:0]       ld_nbytes;
  end_kind_t        ld_end;
  logic [8:0]       ser_data;
  logic [FIFO_AW:0] fifo_free;

  ppp_ctrl #(.SIZE_W(SIZE_W), .FIFO_AW(FIFO_AW)) u_ctrl (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_write(s_write),
    .s_wdata(s_wdata), .fetch_mode(fetch_mode), .abort_req(abort_req),
    .ser_busy(ser_busy), .fifo_free(fifo_free), .s_done(s_done),
    .s_err(s_err), .ld(ld), .ld_word(ld_word), .ld_nbytes(ld_nbytes),
    .ld_end(ld_end), .set_wrong(set_wrong), .set_rderr(set_rderr)
  );

  ppp_serializer u_ser (
    .clk(clk), .rst(rst), .ld(ld), .ld_word(ld_word),
    .ld_nbytes(ld_nbytes), .ld_end(ld_end), .busy(ser_busy),
    .out_valid(ser_valid), .out_data(ser_data)
  );

  ppp_fifo #(.DW(9), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst(rst), .flush(!link_en), .wr_en(ser_valid),
    .wr_data(ser_data), .rd_en(tx_rd), .rd_data(tx_dout),
    .empty(tx_empty), .free(fifo_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_wrong_mode <= 1'b0;
      irq_rd_err     <= 1'b0;
    end else begin
      irq_wrong_mode <= set_wrong || (irq_wrong_mode && !irq_clr[0]);
      irq_rd_err     <= set_rderr || (irq_rd_err && !irq_clr[1]);
    end
  end
endmodule

// File: rtl/ppp_chk.sv
module ppp_chk #(
  parameter int FIFO_AW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_write,
  input logic             fetch_mode,
  input logic             s_done,
  input logic             s_err,
  input logic             link_en,
  input logic             tx_empty,
  input logic [1:0]       irq_clr,
  input logic             irq_rd_err,
  input logic             irq_wrong_mode,
  input logic             ser_valid,
  input logic [FIFO_AW:0] fifo_free
);
  // R6
  rd_err_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_write) |-> (s_err && s_done));
  // R6
  rd_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_write) |=> irq_rd_err);
  // R5
  wrong_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_write && fetch_mode) |=> irq_wrong_mode);
  // R5
  push_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_write && !fetch_mode) |-> !s_err);
  // R8
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !link_en |=> tx_empty);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_rd_err && !irq_clr[1]) |=> irq_rd_err);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && link_en) |-> (fifo_free != '0));
endmodule

bind pkt_push_port ppp_chk #(.FIFO_AW(FIFO_AW)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_write(s_write),
  .fetch_mode(fetch_mode), .s_done(s_done), .s_err(s_err),
  .link_en(link_en), .tx_empty(tx_empty), .irq_clr(irq_clr),
  .irq_rd_err(irq_rd_err), .irq_wrong_mode(irq_wrong_mode),
  .ser_valid(ser_valid), .fifo_free(fifo_free)
);

// File: tb/pkt_push_port_tb_top.sv
module pkt_push_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_mode = 1'b0, link_en = 1'b1, abort_req = 1'b0;
  logic        s_valid = 1'b0, s_write = 1'b0;
  logic [31:0] s_wdata = '0;
  logic        s_done, s_err, tx_empty, irq_wrong_mode, irq_rd_err;
  logic        tx_rd = 1'b0;
  logic [8:0]  tx_dout;
  logic [1:0]  irq_clr = 2'b00;

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  int model_rem = 0;

  always #10 clk = ~clk;

  pkt_push_port dut_i (
    .clk(clk), .rst(rst), .fetch_mode(fetch_mode), .link_en(link_en),
    .abort_req(abort_req), .s_valid(s_valid), .s_write(s_write),
    .s_wdata(s_wdata), .s_done(s_done), .s_err(s_err), .tx_rd(tx_rd),
    .tx_dout(tx_dout), .tx_empty(tx_empty), .irq_clr(irq_clr),
    .irq_wrong_mode(irq_wrong_mode), .irq_rd_err(irq_rd_err)
  );

  // {write, expected error, data}
  localparam logic [33:0] VEC [9] = '{
    {1'b1, 1'b0, 32'd6},
    {1'b1, 1'b0, 32'h4433_2211},
    {1'b1, 1'b0, 32'h8877_6655},
    {1'b0, 1'b1, 32'h0000_0000},
    {1'b1, 1'b0, 32'd4},
    {1'b1, 1'b0, 32'hDDCC_BBAA},
    {1'b1, 1'b0, 32'd0},
    {1'b1, 1'b0, 32'd1},
    {1'b1, 1'b0, 32'h0000_00EE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model of the packet framing, from R1, R2, R3
  task automatic model_write(input logic [31:0] d);
    if (model_rem == 0) begin
      model_rem = int'(d[15:0]);
    end else begin
      int n = (model_rem > 4) ? 4 : model_rem;
      for (int k = 0; k < n; k++) exp_q.push_back({1'b0, d[8*k +: 8]});
      model_rem -= n;
      if (model_rem == 0) exp_q.push_back(9'h100);
    end
  endtask

  // Called at a falling edge; returns at a falling edge
  task automatic bus_op(input logic wr, input logic [31:0] d, output logic err);
    err = 1'b0;
    s_valid = 1'b1; s_write = wr; s_wdata = d;
    for (int i = 0; i < 200; i++) begin
      #1;
      if (s_done) begin
        err = s_err;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic pop_one(input string tag);
    logic [8:0] e;
    #1;
    if (exp_q.size() == 0) begin
      check(tag, {23'd0, tx_dout}, 32'h1FF);
    end else begin
      e = exp_q.pop_front();
      check(tag, {23'd0, tx_dout}, {23'd0, e});
    end
    tx_rd = 1'b1;
    @(negedge clk);
    tx_rd = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 64 && !tx_empty; i++) pop_one(tag);
    check({tag, " leftover"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic err;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R10 reset state
    check("R10 tx_empty", tx_empty, 1);
    check("R10 irq_wrong_mode", irq_wrong_mode, 0);
    check("R10 irq_rd_err", irq_rd_err, 0);
    check("R10 s_done idle", s_done, 0);
    @(negedge clk);

    // Vector table, back-to-back transfers (R1 R2 R3 R4 R6)
    for (int i = 0; i < 9; i++) begin
      bus_op(VEC[i][33], VEC[i][31:0], err);
      check($sformatf("R6 R4 vector %0d error response", i), err, VEC[i][32]);
      if (VEC[i][33] && !err) model_write(VEC[i][31:0]);
    end
    check("R6 irq_rd_err set", irq_rd_err, 1);
    drain("R2 R3 R11 table entries");

    // R5 wrong-mode write: error, flag, no effect
    fetch_mode = 1'b1;
    bus_op(1'b1, 32'd3, err);
    check("R5 wrong-mode error", err, 1);
    check("R5 wrong-mode flag", irq_wrong_mode, 1);
    repeat (4) @(negedge clk);
    check("R5 fifo untouched", tx_empty, 1);
    fetch_mode = 1'b0;
    bus_op(1'b1, 32'd2, err); model_write(32'd2);
    bus_op(1'b1, 32'h0000_BEEF, err); model_write(32'h0000_BEEF);
    drain("R5 state unchanged");

    // R9 sticky and write-one-to-clear
    check("R9 rd flag still set", irq_rd_err, 1);
    irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00; #1;
    check("R9 clear wrong-mode", irq_wrong_mode, 0);
    check("R9 other flag kept", irq_rd_err, 1);
    @(negedge clk);
    irq_clr = 2'b10; @(negedge clk); irq_clr = 2'b00; #1;
    check("R9 clear rd flag", irq_rd_err, 0);
    @(negedge clk);

    // R7 abort in payload state
    bus_op(1'b1, 32'd8, err); model_write(32'd8);
    bus_op(1'b1, 32'h0403_0201, err); model_write(32'h0403_0201);
    repeat (6) @(negedge clk);
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    exp_q.push_back(9'h101); model_rem = 0;
    drain("R7 abort in payload");
    bus_op(1'b1, 32'd1, err); model_write(32'd1);
    bus_op(1'b1, 32'h0000_005A, err); model_write(32'h0000_005A);
    drain("R7 back to length state");

    // R7 abort in length state
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    exp_q.push_back(9'h101);
    drain("R7 abort in length state");

    // R8 flush on link disable
    bus_op(1'b1, 32'd4, err);
    bus_op(1'b1, 32'h1122_3344, err);
    repeat (8) @(negedge clk);
    #1 check("R8 data present", tx_empty, 0);
    @(negedge clk);
    link_en = 1'b0; @(negedge clk); link_en = 1'b1; #1;
    check("R8 flushed", tx_empty, 1);
    @(negedge clk);

    // R4 wait states when the FIFO lacks room
    bus_op(1'b1, 32'd40, err); model_write(32'd40);
    for (int w = 0; w < 4; w++) begin
      bus_op(1'b1, 32'h0A0B_0C00 + 32'(w), err); model_write(32'h0A0B_0C00 + 32'(w));
    end
    repeat (6) @(negedge clk);
    s_valid = 1'b1; s_write = 1'b1; s_wdata = 32'h5555_0004;
    for (int i = 0; i < 10; i++) begin
      #1 check("R4 wait state while full", s_done, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) pop_one("R4 R11 pop during stall");
    bus_op(1'b1, 32'h5555_0004, err); model_write(32'h5555_0004);
    check("R4 accepted after room", err, 0);
    for (int w = 5; w < 10; w++) begin
      drain("R4 stalled packet");
      bus_op(1'b1, 32'h6666_0000 + 32'(w), err); model_write(32'h6666_0000 + 32'(w));
    end
    drain("R3 R4 end of long packet");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule